// File: doc/BRIEF.md
# Exp-Golomb Serial Codeword Decoder

This block turns a serial stream of unsigned Exp-Golomb codewords into parallel numbers. Bits arrive one per cycle, most significant first, through a valid/ready handshake. The decoder counts the run of zeros that opens each codeword. It then gathers the marker one and as many information bits as there were zeros. It presents the decoded number together with the codeword length in bits and a one-cycle valid strobe.

The code has no fixed field width. Small numbers take only a few bits, and large numbers take up to 63. A codeword with a run of L zeros spans 2L+1 bits. It decodes to 2^L − 1 plus the L information bits read as a binary number. A run-time mode input can fold the decoded number onto the signed integers. The output is 32 bits wide. A zero run longer than the output can represent is reported on a sticky error output.

Top module: `expgol_decoder`

## Requirements
- R1: After reset, out_valid and err_flag are 0 and bit_ready is 1.
- R2: A codeword made of a single 1 bit (no leading zeros) decodes to value 0 with out_len 1.
- R3: For a codeword of L zeros, a 1, then L information bits sent most significant first, the unsigned result is 2^L − 1 plus the information bits as a binary number. For example, ten zeros followed by 11001000001 (21 bits) gives 1600.
- R4: out_len equals 2L+1 for every decoded codeword.
- R5: out_valid is high for exactly one cycle, the cycle after the last bit of a codeword is accepted. bit_ready is 0 in that cycle and returns to 1 in the following cycle.
- R6: A bit is accepted only in a cycle where bit_valid and bit_ready are both 1. Values on bit_data while bit_valid is 0 have no effect.
- R7: When signed_mode is 1 during the output cycle, an unsigned result k is presented in two's complement. An odd k becomes (k+1)/2 and an even k becomes −k/2 (0→0, 1→1, 2→−1, 3→2, 4→−2).
- R8: Accepting the 32nd consecutive zero of one prefix sets err_flag. That codeword is dropped with no out_valid, and counting restarts. err_flag stays 1 until reset, and later codewords still decode.
- R9: The longest legal codeword, 31 zeros, a 1 and 31 information bits, decodes without error. With 31 ones as information it gives 0xFFFFFFFE and out_len 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | A stream bit is offered on bit_data |
| bit_data | input | 1 | Stream bit, codeword order |
| bit_ready | output | 1 | Decoder can take a bit this cycle |
| signed_mode | input | 1 | 1 selects the signed folding of the result |
| out_valid | output | 1 | One-cycle strobe: out_value and out_len hold a result |
| out_value | output | 32 | Decoded number (unsigned or signed by signed_mode) |
| out_len | output | 6 | Length of the decoded codeword in bits |
| err_flag | output | 1 | Sticky: a zero prefix exceeded 31 bits |

## Verification
The result strobe and a stall of the input handshake fall in the same cycle. The decoder refuses a bit while it presents a result. The bench provokes this by keeping bit_valid high straight after the last bit of a codeword, with the first bit of the next codeword already offered. It then checks three things: the strobe and the low bit_ready coincide, the offered bit is neither lost nor consumed twice, and the following codeword decodes to its expected value. The sticky error is also set against continuing decoding, by following an over-long prefix directly with a valid codeword.

// File: rtl/expgol_pkg.sv
package expgol_pkg;

   typedef enum logic [1:0] {
      ST_PREFIX = 2'd0,
      ST_SUFFIX = 2'd1,
      ST_DONE   = 2'd2
   } dec_state_e;

   // Fold an unsigned code number onto the signed integers:
   // odd k -> (k+1)/2, even k -> -(k/2)
   function automatic logic [31:0] fold_signed(input logic [31:0] k);
      logic [31:0] half;
      half = k >> 1;
      if (k[0]) return half + 32'd1;
      else      return (~half) + 32'd1;
   endfunction

endpackage

// File: rtl/expgol_prefix_count.sv
module expgol_prefix_count #(
   parameter int MAX_ZEROS = 31,
   localparam int ZCNT_W   = $clog2(MAX_ZEROS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero_take,
   input  logic              clear,
   output logic [ZCNT_W-1:0] zcnt,
   output logic              overflow,
   output logic              err_flag
);

   localparam logic [ZCNT_W-1:0] ZMAX = ZCNT_W'(MAX_ZEROS);

   assign overflow = zero_take && (zcnt == ZMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zcnt <= '0;
      end else if (clear || overflow) begin
         zcnt <= '0;
      end else if (zero_take) begin
         zcnt <= zcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_flag <= 1'b0;
      else if (overflow) err_flag <= 1'b1;
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R8
   AST_OVF_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> (err_flag && zcnt == '0)); // R8

endmodule

// File: rtl/expgol_suffix_shift.sv
module expgol_suffix_shift #(
   parameter int VAL_W  = 32,
   parameter int ZCNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ZCNT_W-1:0] load_cnt,
   input  logic              shift,
   input  logic              shift_bit,
   output logic [VAL_W-1:0]  acc,
   output logic              last
);

   logic [ZCNT_W-1:0] remain;

   assign last = shift && (remain == ZCNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         remain <= '0;
      end else if (load) begin
         acc    <= VAL_W'(1);
         remain <= load_cnt;
      end else if (shift) begin
         acc    <= {acc[VAL_W-2:0], shift_bit};
         remain <= remain - 1'b1;
      end
   end

endmodule

// File: rtl/expgol_value_map.sv
module expgol_value_map #(
   parameter int VAL_W      = 32,
   parameter bit HAS_SIGNED = 1'b1
) (
   input  logic [VAL_W-1:0] acc,
   input  logic             signed_mode,
   output logic [VAL_W-1:0] codenum,
   output logic [VAL_W-1:0] value
);

   assign codenum = acc - VAL_W'(1);

   generate
      if (HAS_SIGNED) begin : g_signed
         logic [VAL_W-1:0] half;
         assign half  = codenum >> 1;
         assign value = !signed_mode ? codenum :
                        codenum[0]   ? half + VAL_W'(1) :
                                       (~half) + VAL_W'(1);
      end else begin : g_unsigned
         assign value = signed_mode ? codenum : codenum;
      end
   endgenerate

endmodule

// File: rtl/expgol_decoder.sv
module expgol_decoder
   import expgol_pkg::*;
#(
   parameter int VAL_W      = 32,
   parameter int MAX_ZEROS  = 31,
   parameter bit HAS_SIGNED = 1'b1,
   localparam int ZCNT_W    = $clog2(MAX_ZEROS + 1),
   localparam int LEN_W     = ZCNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_data,
   output logic             bit_ready,
   input  logic             signed_mode,
   output logic             out_valid,
   output logic [VAL_W-1:0] out_value,
   output logic [LEN_W-1:0] out_len,
   output logic             err_flag
);

   generate
      if (MAX_ZEROS >= VAL_W) begin : g_bad_zeros
         $error("MAX_ZEROS must be below VAL_W");
      end
      if (VAL_W < 2) begin : g_bad_width
         $error("VAL_W must be at least 2");
      end
   endgenerate

   dec_state_e        state, state_nx;
   logic              take, zero_take, one_take, clear;
   logic              overflow, last, sfx_shift;
   logic [ZCNT_W-1:0] zcnt;
   logic [VAL_W-1:0]  acc, codenum;

   assign bit_ready = (state != ST_DONE);
   assign take      = bit_valid && bit_ready;
   assign zero_take = take && (state == ST_PREFIX) && !bit_data;
   assign one_take  = take && (state == ST_PREFIX) &&  bit_data;
   assign sfx_shift = take && (state == ST_SUFFIX);
   assign clear     = (state == ST_DONE);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_PREFIX: if (one_take) state_nx = (zcnt == '0) ? ST_DONE : ST_SUFFIX;
         ST_SUFFIX: if (last)     state_nx = ST_DONE;
         ST_DONE:                 state_nx = ST_PREFIX;
         default:                 state_nx = ST_PREFIX;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_PREFIX;
      else        state <= state_nx;
   end

   expgol_prefix_count #(.MAX_ZEROS(MAX_ZEROS)) prefix_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .zero_take (zero_take),
      .clear     (clear),
      .zcnt      (zcnt),
      .overflow  (overflow),
      .err_flag  (err_flag)
   );

   expgol_suffix_shift #(.VAL_W(VAL_W), .ZCNT_W(ZCNT_W)) suffix_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (one_take),
      .load_cnt  (zcnt),
      .shift     (sfx_shift),
      .shift_bit (bit_data),
      .acc       (acc),
      .last      (last)
   );

   expgol_value_map #(.VAL_W(VAL_W), .HAS_SIGNED(HAS_SIGNED)) map_i (
      .acc         (acc),
      .signed_mode (signed_mode),
      .codenum     (codenum),
      .value       (out_value)
   );

   assign out_valid = (state == ST_DONE);
   assign out_len   = {zcnt, 1'b1};

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R5
   AST_STALL_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !bit_ready); // R5
   AST_LEN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_len[0]); // R4
   AST_LONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len == LEN_W'(1)) |-> (codenum == '0)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PREFIX && !bit_valid) |=> ($stable(zcnt) && !out_valid)); // R6

endmodule

// File: tb/expgol_decoder_tb_top.sv
module expgol_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   // table: zero count, information bits, signed mode, expected value, expected length
   localparam int          T_L  [NV] = '{0, 1, 1, 2, 5, 10, 31,
                                         0, 1, 1, 2, 2, 10, 31};
   localparam logic [31:0] T_I  [NV] = '{32'd0, 32'd0, 32'd1, 32'd1, 32'd0, 32'd577, 32'h7FFFFFFF,
                                         32'd0, 32'd0, 32'd1, 32'd0, 32'd1, 32'd577, 32'h7FFFFFFF};
   localparam bit          T_S  [NV] = '{0, 0, 0, 0, 0, 0, 0,
                                         1, 1, 1, 1, 1, 1, 1};
   localparam logic [31:0] T_V  [NV] = '{32'd0, 32'd1, 32'd2, 32'd4, 32'd31, 32'd1600, 32'hFFFFFFFE,
                                         32'd0, 32'd1, 32'hFFFFFFFF, 32'd2, 32'hFFFFFFFE,
                                         32'hFFFFFCE0, 32'h80000001};
   localparam string       T_R  [NV] = '{"R2", "R3", "R3", "R3", "R4", "R3", "R9",
                                         "R7", "R7", "R7", "R7", "R7", "R7", "R7"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_data = 1'b0;
   logic        signed_mode = 1'b0;
   logic        bit_ready, out_valid, err_flag;
   logic [31:0] out_value;
   logic [5:0]  out_len;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   expgol_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_valid   (bit_valid),
      .bit_data    (bit_data),
      .bit_ready   (bit_ready),
      .signed_mode (signed_mode),
      .out_valid   (out_valid),
      .out_value   (out_value),
      .out_len     (out_len),
      .err_flag    (err_flag)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic send_bit(input logic b);
      bit_valid = 1'b1;
      bit_data  = b;
      while (!bit_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send_code(input int l, input logic [31:0] info);
      for (int i = 0; i < l; i++) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = l - 1; i >= 0; i--) send_bit(info[i]);
   endtask

   task automatic do_reset();
      bit_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
      chk(err_flag == 1'b0, "R1 err_flag", 32'(err_flag), 32'd0);
      chk(bit_ready == 1'b1, "R1 bit_ready", 32'(bit_ready), 32'd1);

      // table walk
      for (int v = 0; v < NV; v++) begin
         signed_mode = T_S[v];
         send_code(T_L[v], T_I[v]);
         bit_valid = 1'b0;
         chk(out_valid == 1'b1, {T_R[v], " strobe"}, 32'(out_valid), 32'd1);
         chk(out_value == T_V[v], {T_R[v], " value"}, out_value, T_V[v]);
         chk(out_len == 6'(2 * T_L[v] + 1), "R4 length", 32'(out_len), 32'(2 * T_L[v] + 1));
         chk(bit_ready == 1'b0, "R5 ready low on strobe", 32'(bit_ready), 32'd0);
         @(negedge clk);
         chk(out_valid == 1'b0, "R5 strobe one cycle", 32'(out_valid), 32'd0);
         chk(bit_ready == 1'b1, "R5 ready back", 32'(bit_ready), 32'd1);
      end
      signed_mode = 1'b0;

      // R6: ones offered with bit_valid low must not start a codeword
      bit_valid = 1'b0;
      bit_data  = 1'b1;
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
         end
         chk(!seen, "R6 idle bits ignored", 32'(seen), 32'd0);
      end
      // R6: a zero prefix interrupted by idle cycles still decodes correctly (00 idle 1 01 -> 4)
      send_bit(1'b0);
      bit_valid = 1'b0; bit_data = 1'b1;
      repeat (3) @(negedge clk);
      send_bit(1'b0);
      send_bit(1'b1);
      bit_valid = 1'b0; bit_data = 1'b1;
      repeat (2) @(negedge clk);
      send_bit(1'b0);
      send_bit(1'b1);
      bit_valid = 1'b0;
      chk(out_valid && out_value == 32'd4, "R6 gaps inside codeword", out_value, 32'd4);
      @(negedge clk);

      // R5: strobe and handshake stall in the same cycle, next bit held and not lost
      send_code(0, 32'd0);              // "1" -> 0, bit_valid stays high
      chk(out_valid == 1'b1 && bit_ready == 1'b0, "R5 strobe with stall", 32'(bit_ready), 32'd0);
      send_code(1, 32'd1);              // "011" -> 2, first bit offered during the stall
      bit_valid = 1'b0;
      chk(out_valid && out_value == 32'd2 && out_len == 6'd3, "R5 bit after stall", out_value, 32'd2);
      @(negedge clk);

      // R8: over-long prefix sets sticky error, no strobe, decoding continues
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 32; i++) begin
            send_bit(1'b0);
            if (out_valid) seen = 1'b1;
         end
         chk(err_flag == 1'b1, "R8 error set", 32'(err_flag), 32'd1);
         chk(!seen, "R8 no strobe for dropped codeword", 32'(seen), 32'd0);
      end
      send_code(1, 32'd0);              // "010" -> 1
      bit_valid = 1'b0;
      chk(out_valid && out_value == 32'd1 && out_len == 6'd3, "R8 decode after error", out_value, 32'd1);
      @(negedge clk);
      chk(err_flag == 1'b1, "R8 error sticky", 32'(err_flag), 32'd1);
      do_reset();
      chk(err_flag == 1'b0, "R8 error cleared by reset", 32'(err_flag), 32'd0);

      // R9: 31 zeros is still legal, no error
      send_code(31, 32'd0);
      bit_valid = 1'b0;
      chk(out_valid && out_value == 32'h7FFFFFFF && err_flag == 1'b0, "R9 longest prefix", out_value, 32'h7FFFFFFF);
      @(negedge clk);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule